// File: doc/BRIEF.md
# Timing pulse and interval generator

This block divides a fast reference clock (nominally 32.768 kHz) with a binary ripple-free divider of `DIV_STAGES` stages. It produces two things: a one-cycle tick once per second for the calendar counter, and a single active-low timing output, `tp_n`. The output has two uses. In frequency mode it carries a square wave at one of four rates taken from the divider. In interval mode it carries a sticky flag that sets each time a selected number of seconds has passed.

A command decoder drives the block with single-cycle strobes. One strobe loads a square-wave rate and returns the output to frequency mode. Another selects a seconds interval; it clears the interval count and the flag, starts the timer and switches the output to interval mode. Further strobes clear the flag, resume the timer and pause it. After reset the output runs in frequency mode at 64 Hz, the interval timer is stopped and the flag is clear. The reset input is asserted asynchronously and released on the clock through a two-stage synchronizer.

Top module: `tp_interval_gen`

## Requirements
- R1: `sec_tick` is high for exactly one clock cycle, once every 2^DIV_STAGES cycles.
- R2: In frequency mode `tp_n` is a square wave whose half period is 2^(DIV_STAGES-7), 2^(DIV_STAGES-9), 2^(DIV_STAGES-12) or 2^(DIV_STAGES-13) cycles for `rate_code` 0, 1, 2, 3 (64, 256, 2048 and 4096 Hz at 15 stages). A rate that would need a stage below the first uses the first stage, which gives a half period of one cycle.
- R3: After reset the block is in frequency mode at rate code 0.
- R4: An `ivl_load` strobe clears the count and the flag, starts the timer and selects interval mode. `tp_n` then stays high and first goes low exactly N*2^DIV_STAGES cycles after the strobe edge.
- R5: `ivl_code` 0, 1, 2, 3 selects N = 1, 10, 30, 60 seconds.
- R6: Once set, the flag holds `tp_n` low until `flag_clear` or `ivl_load`.
- R7: When the interval ends the count restarts from zero and keeps counting, so successive flag sets are N*2^DIV_STAGES cycles apart, whether or not the flag was cleared in between.
- R8: A `flag_clear` strobe releases `tp_n` high on the next cycle, unless the interval ends on that same edge, in which case the flag stays set.
- R9: `tmr_stop` pauses the count without changing it, and `tmr_run` resumes it. The flag time moves later by exactly the number of paused cycles.
- R10: While the timer is stopped the flag never sets. When `tmr_stop` and `tmr_run` arrive together, the stop takes effect.
- R11: A `rate_load` strobe returns `tp_n` to the square wave even while the flag is set. `ivl_load` takes priority over `rate_load` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 2^DIV_STAGES cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_load | input | 1 | Strobe: load `rate_code` and enter frequency mode |
| rate_code | input | 2 | Square-wave rate: 0=64 Hz, 1=256 Hz, 2=2048 Hz, 3=4096 Hz |
| ivl_load | input | 1 | Strobe: load `ivl_code`, restart and run the timer, enter interval mode |
| ivl_code | input | 2 | Interval: 0=1 s, 1=10 s, 2=30 s, 3=60 s |
| flag_clear | input | 1 | Strobe: clear the interval flag |
| tmr_run | input | 1 | Strobe: resume the interval timer |
| tmr_stop | input | 1 | Strobe: pause the interval timer |
| tp_n | output | 1 | Active-low timing output (1 = released) |
| sec_tick | output | 1 | One-cycle pulse once per second |

## Verification
The bench builds two instances. One uses the default of 15 divider stages and shows the real square-wave half periods of 256, 64, 8 and 4 cycles, the 64 Hz default after reset and a one-second tick of 32768 cycles. The other uses 6 stages, so a second lasts 64 cycles. This brings every interval up to 60 seconds (3840 cycles), the rollover after a flag clear, and exact pause and resume arithmetic within a short run. At 6 stages every rate falls back to the first stage, which the return-to-frequency check relies on.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    RATE_64  = 2'd0,
    RATE_256 = 2'd1,
    RATE_2K  = 2'd2,
    RATE_4K  = 2'd3
  } rate_e;

  typedef enum logic [1:0] {
    IVL_1S  = 2'd0,
    IVL_10S = 2'd1,
    IVL_30S = 2'd2,
    IVL_60S = 2'd3
  } ivl_e;

  typedef enum logic {
    MODE_FREQ = 1'b0,
    MODE_IVL  = 1'b1
  } tp_mode_e;

  // octaves above 1 Hz for each square-wave rate
  function automatic int rate_octaves(int code);
    case (code)
      0:       return 6;
      1:       return 8;
      2:       return 11;
      default: return 12;
    endcase
  endfunction

  // divider bit for a rate; clamps to stage 0 when the divider is short
  function automatic int tap_index(int stages, int code);
    int t;
    t = stages - 1 - rate_octaves(code);
    return (t < 0) ? 0 : t;
  endfunction

  function automatic logic [5:0] ivl_seconds(ivl_e sel);
    case (sel)
      IVL_1S:  return 6'd1;
      IVL_10S: return 6'd10;
      IVL_30S: return 6'd30;
      default: return 6'd60;
    endcase
  endfunction

endpackage

// File: rtl/tpg_divider.sv
module tpg_divider
  import tpg_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic       clk,
  input  logic       arst_n,
  output logic [3:0] taps,
  output logic       sec_tick
);

  logic [STAGES-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) div_q <= '0;
    else         div_q <= div_d;
  end

  assign sec_tick = &div_q;

  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int TI = tap_index(STAGES, g);
    assign taps[g] = div_q[TI];
  end

endmodule

// File: rtl/tpg_interval.sv
module tpg_interval
  import tpg_pkg::*;
#(
  parameter int STAGES = 15,
  localparam int CNT_W = STAGES + 6
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load,
  input  ivl_e             code,
  input  logic             flag_clr,
  input  logic             run,
  input  logic             stop,
  output logic             flag,
  output logic             running,
  output logic             term,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  ivl_e             sel_q, sel_d;
  logic             term_hit;

  always_comb begin
    last_cnt = (CNT_W'(ivl_seconds(sel_q)) << STAGES) - CNT_W'(1);
    term_hit = run_q && (cnt_q == last_cnt);
  end

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    flag_d = flag_q;
    sel_d  = sel_q;
    if (load) begin
      cnt_d  = '0;
      run_d  = 1'b1;
      flag_d = 1'b0;
      sel_d  = code;
    end else begin
      if (run_q)         cnt_d = term_hit ? '0 : cnt_q + 1'b1;
      if (stop)          run_d = 1'b0;
      else if (run)      run_d = 1'b1;
      if (term_hit)      flag_d = 1'b1;
      else if (flag_clr) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      sel_q  <= IVL_1S;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      sel_q  <= sel_d;
    end
  end

  assign flag    = flag_q;
  assign running = run_q;
  assign term    = term_hit;
  assign cnt     = cnt_q;

endmodule

// File: rtl/tpg_outmux.sv
module tpg_outmux
  import tpg_pkg::*;
(
  input  logic [3:0] taps,
  input  rate_e      rate,
  input  tp_mode_e   mode,
  input  logic       flag,
  output logic       tp_n
);

  always_comb begin
    if (mode == MODE_IVL) tp_n = ~flag;
    else                  tp_n = taps[rate];
  end

endmodule

// File: rtl/tp_interval_gen.sv
module tp_interval_gen
  import tpg_pkg::*;
#(
  parameter int DIV_STAGES = 15,
  localparam int CNT_W = DIV_STAGES + 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_load,
  input  logic [1:0] rate_code,
  input  logic       ivl_load,
  input  logic [1:0] ivl_code,
  input  logic       flag_clear,
  input  logic       tmr_run,
  input  logic       tmr_stop,
  output logic       tp_n,
  output logic       sec_tick
);

  logic [1:0]       rst_pipe;
  logic             arst_n;
  tp_mode_e         mode_q, mode_d;
  rate_e            rate_q, rate_d;
  logic [3:0]       taps;
  logic             ivl_flag, ivl_running, ivl_term;
  logic [CNT_W-1:0] ivl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  always_comb begin
    mode_d = mode_q;
    rate_d = rate_q;
    if (ivl_load) begin
      mode_d = MODE_IVL;
    end else if (rate_load) begin
      mode_d = MODE_FREQ;
      rate_d = rate_e'(rate_code);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= MODE_FREQ;
      rate_q <= RATE_64;
    end else begin
      mode_q <= mode_d;
      rate_q <= rate_d;
    end
  end

  tpg_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk      (clk),
    .arst_n   (arst_n),
    .taps     (taps),
    .sec_tick (sec_tick)
  );

  tpg_interval #(.STAGES(DIV_STAGES)) u_ivl (
    .clk      (clk),
    .arst_n   (arst_n),
    .load     (ivl_load),
    .code     (ivl_e'(ivl_code)),
    .flag_clr (flag_clear),
    .run      (tmr_run),
    .stop     (tmr_stop),
    .flag     (ivl_flag),
    .running  (ivl_running),
    .term     (ivl_term),
    .cnt      (ivl_cnt)
  );

  tpg_outmux u_mux (
    .taps (taps),
    .rate (rate_q),
    .mode (mode_q),
    .flag (ivl_flag),
    .tp_n (tp_n)
  );

endmodule

// File: rtl/tp_interval_gen_chk.sv
module tp_interval_gen_chk #(
  parameter int STAGES = 15,
  localparam int CNT_W = STAGES + 6
) (
  input logic             clk,
  input logic             arst_n,
  input logic             sec_tick,
  input logic             ivl_load,
  input logic             rate_load,
  input logic             flag_clear,
  input logic             mode_ivl,
  input logic             flag,
  input logic             running,
  input logic             term,
  input logic [CNT_W-1:0] cnt
);

  // R1
  tick_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sec_tick |=> !sec_tick);

  // R4
  load_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ivl_load |=> (mode_ivl && !flag && running && cnt == '0));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (flag && !flag_clear && !ivl_load) |=> flag);

  // R7
  term_reload_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (term && !ivl_load) |=> (flag && cnt == '0));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (flag_clear && !term && !ivl_load) |=> !flag);

  // R9
  pause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!running && !ivl_load) |=> $stable(cnt));

  // R11
  freq_return_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (rate_load && !ivl_load) |=> !mode_ivl);

endmodule

bind tp_interval_gen tp_interval_gen_chk #(.STAGES(DIV_STAGES)) u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .sec_tick   (sec_tick),
  .ivl_load   (ivl_load),
  .rate_load  (rate_load),
  .flag_clear (flag_clear),
  .mode_ivl   (mode_q == tpg_pkg::MODE_IVL),
  .flag       (ivl_flag),
  .running    (ivl_running),
  .term       (ivl_term),
  .cnt        (ivl_cnt)
);

// File: tb/sim_tp_interval_gen.sv
module sim_tp_interval_gen;

  localparam int CLK_PERIOD = 10;
  localparam int S0 = 6;
  localparam int S1 = 15;
  localparam int SEC0 = 1 << S0;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n;
  logic r0_load, i_load, f_clr, t_run, t_stop, r1_load;
  logic [1:0] r0_code, i_code, r1_code;
  logic tp0_n, tick0, tp1_n, tick1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_interval_gen #(.DIV_STAGES(S0)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rate_load(r0_load), .rate_code(r0_code),
    .ivl_load(i_load), .ivl_code(i_code),
    .flag_clear(f_clr), .tmr_run(t_run), .tmr_stop(t_stop),
    .tp_n(tp0_n), .sec_tick(tick0)
  );

  tp_interval_gen #(.DIV_STAGES(S1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .rate_load(r1_load), .rate_code(r1_code),
    .ivl_load(1'b0), .ivl_code(2'b00),
    .flag_clear(1'b0), .tmr_run(1'b0), .tmr_stop(1'b0),
    .tp_n(tp1_n), .sec_tick(tick1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wait_tp0_low(input int limit, output int n);
    n = 0;
    while (tp0_n && n < limit) begin
      step(1);
      n++;
    end
  endtask

  task automatic half_period1(output int hp);
    logic lv;
    int guard;
    lv = tp1_n;
    guard = 0;
    while (tp1_n == lv && guard < 70000) begin step(1); guard++; end
    lv = tp1_n;
    hp = 0;
    while (tp1_n == lv && hp < 70000) begin step(1); hp++; end
  endtask

  task automatic load_ivl(input logic [1:0] code);
    i_code = code;
    i_load = 1'b1;
    step(1);
    i_load = 1'b0;
  endtask

  // R3: 64 Hz square wave after reset
  task automatic test_reset_default();
    int hp;
    half_period1(hp);
    check(hp == 256, "R3 first half period", hp, 256);
    half_period1(hp);
    check(hp == 256, "R3 second half period", hp, 256);
  endtask

  // R1: tick width and spacing on both instances
  task automatic test_tick();
    int n;
    n = 0;
    while (!tick0 && n < 200) begin step(1); n++; end
    step(1);
    check(tick0 == 1'b0, "R1 tick width", tick0, 0);
    n = 1;
    while (!tick0 && n < 200) begin step(1); n++; end
    check(n == SEC0, "R1 tick spacing small", n, SEC0);
    n = 0;
    while (!tick1 && n < 40000) begin step(1); n++; end
    step(1);
    n = 1;
    while (!tick1 && n < 40000) begin step(1); n++; end
    check(n == (1 << S1), "R1 tick spacing full", n, 1 << S1);
  endtask

  // R2: all four rates at full divider length
  task automatic test_rates();
    int hp;
    int exp_hp;
    for (int c = 0; c < 4; c++) begin
      r1_code = c[1:0];
      r1_load = 1'b1;
      step(1);
      r1_load = 1'b0;
      case (c)
        0: exp_hp = 256;
        1: exp_hp = 64;
        2: exp_hp = 8;
        default: exp_hp = 4;
      endcase
      half_period1(hp);
      check(hp == exp_hp, "R2 half period a", hp, exp_hp);
      half_period1(hp);
      check(hp == exp_hp, "R2 half period b", hp, exp_hp);
    end
  endtask

  // R4, R5, R6: each interval length and the held flag
  task automatic test_intervals();
    int n;
    int secs;
    bit held;
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: secs = 1;
        1: secs = 10;
        2: secs = 30;
        default: secs = 60;
      endcase
      load_ivl(c[1:0]);
      check(tp0_n == 1'b1, "R4 released after load", tp0_n, 1);
      wait_tp0_low(secs * SEC0 + 10, n);
      check(n == secs * SEC0, "R5 interval length", n, secs * SEC0);
      held = 1'b1;
      for (int k = 0; k < 80; k++) begin
        step(1);
        if (tp0_n) held = 1'b0;
      end
      check(held, "R6 flag held low", held, 1);
    end
  endtask

  // R7, R8: clear mid-period, next set stays on the period grid
  task automatic test_rollover();
    int n;
    load_ivl(2'd0);
    wait_tp0_low(SEC0 + 10, n);
    check(n == SEC0, "R4 first set", n, SEC0);
    step(5);
    f_clr = 1'b1;
    step(1);
    f_clr = 1'b0;
    check(tp0_n == 1'b1, "R8 clear releases", tp0_n, 1);
    wait_tp0_low(SEC0 + 10, n);
    check(n == SEC0 - 6, "R7 next set on grid", n, SEC0 - 6);
  endtask

  // R9: pause and resume
  task automatic test_pause();
    int n;
    load_ivl(2'd0);
    step(9);
    t_stop = 1'b1;
    step(1);
    t_stop = 1'b0;
    step(19);
    t_run = 1'b1;
    step(1);
    t_run = 1'b0;
    check(tp0_n == 1'b1, "R9 no flag during pause", tp0_n, 1);
    wait_tp0_low(200, n);
    check(n == 54, "R9 resumed remaining cycles", n, 54);
  endtask

  // R10: stop wins over run, stopped timer never flags
  task automatic test_stop_hold();
    int n;
    bit high;
    load_ivl(2'd0);
    t_stop = 1'b1;
    t_run = 1'b1;
    step(1);
    t_stop = 1'b0;
    t_run = 1'b0;
    high = 1'b1;
    for (int k = 0; k < 200; k++) begin
      step(1);
      if (!tp0_n) high = 1'b0;
    end
    check(high, "R10 stopped timer silent", high, 1);
    t_run = 1'b1;
    step(1);
    t_run = 1'b0;
    wait_tp0_low(200, n);
    check(n == SEC0 - 1, "R9 resume keeps count", n, SEC0 - 1);
  endtask

  // R11: rate load overrides a set flag; ivl_load beats rate_load
  task automatic test_freq_return();
    logic a, b;
    check(tp0_n == 1'b0, "R11 flag set before", tp0_n, 0);
    r0_code = 2'd0;
    r0_load = 1'b1;
    step(1);
    r0_load = 1'b0;
    step(1);
    a = tp0_n;
    step(1);
    b = tp0_n;
    check(a != b, "R11 square wave resumed", b, !a);
    r0_load = 1'b1;
    i_code = 2'd0;
    i_load = 1'b1;
    step(1);
    r0_load = 1'b0;
    i_load = 1'b0;
    a = tp0_n;
    step(1);
    b = tp0_n;
    check(a == 1'b1 && b == 1'b1, "R11 interval load has priority", {a, b}, 3);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    r0_load = 1'b0; i_load = 1'b0; f_clr = 1'b0;
    t_run = 1'b0; t_stop = 1'b0; r1_load = 1'b0;
    r0_code = 2'd0; i_code = 2'd0; r1_code = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    step(4);
    test_reset_default();
    test_tick();
    test_rates();
    test_intervals();
    test_rollover();
    test_pause();
    test_stop_hold();
    test_freq_return();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule